// File: doc/BRIEF.md
# JTAG Test Access Controller with Auxiliary Handover

This block is a test access port controller clocked by TCK. It follows the standard sixteen-state TAP state machine, which is steered by TMS and reset by TRST. It holds a 5-bit instruction register. The loaded instruction selects one of three data registers between the serial input TDI and the serial output TDO: a fixed 32-bit identification word, a boundary scan chain of parameterized length, or a 1-bit bypass stage. The boundary scan chain here is a stub. It samples a vector of functional pin values, and it can drive a held vector onto the pad outputs in place of the core's own outputs.

Three instructions hand the whole port to one of three auxiliary sub-controllers. The block then raises that controller's grant line, forwards TDI to it and returns its serial output on TDO. The block keeps tracking the state machine while the grant is in force, so that a test-logic reset can take the port back.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: TRST high at a rising TCK edge, or TMS high on five consecutive rising edges, puts the controller in Test-Logic-Reset. In that state the current instruction becomes IDCODE (00001) and every auxiliary grant clears.
- R2: In Capture-IR the instruction shifter loads 00001. It is shifted out least significant bit first, so the first TDO bit of an instruction scan is 1 and the next four are 0.
- R3: The current instruction changes only when the controller passes through Update-IR, where it takes the shifted value, or through Test-Logic-Reset.
- R4: Under IDCODE (00001), a data scan returns the 32-bit identification parameter least significant bit first, with bit 0 always 1.
- R5: BYPASS (11111) and every opcode outside the map below select a 1-bit register. That register captures 0, so TDO shows 0 and then TDI delayed by one TCK. The unmapped opcodes include the factory-reserved codes 00101, 00110 and 01010.
- R6: Under SAMPLE/PRELOAD (00010), Capture-DR loads `pin_in` into the chain and Update-DR copies the shifted chain into the hold register. `pad_out` keeps following `core_out` and `func_reset` stays low.
- R7: Under SAMPLE (00011), Capture-DR loads `pin_in` into the chain, but Update-DR leaves the hold register unchanged.
- R8: Under EXTEST (00100), `pad_out` shows the hold register and `func_reset` is high. The chain still captures `pin_in`, and Update-DR refreshes the hold register.
- R9: Opcode 11011 grants `aux_grant[0]`, opcode 10001 grants `aux_grant[1]` and opcode 10000 grants `aux_grant[2]`. At most one grant bit is ever high. The owner's `aux_tdi` follows TDI while the other two stay 0, and TDO with `tdo_oe` high come from the owner's `aux_tdo` bit.
- R10: A grant stays in force through further instruction and data scans. Only Test-Logic-Reset removes it.
- R11: A data scan cut short after any number of bits leaves no residue. The next Capture-DR reloads the selected register in full.
- R12: When no grant is active, `tdo_oe` is high only in Shift-IR and Shift-DR, and TDO changes only on the falling edge of TCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Test reset, active high, sampled on TCK edges |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Output enable for TDO |
| pin_in | input | BSR_LEN | Functional pin values sampled by the scan chain |
| core_out | input | BSR_LEN | Functional output values from the core |
| pad_out | output | BSR_LEN | Values presented to the pads |
| func_reset | output | 1 | Functional reset, high under EXTEST |
| aux_grant | output | 3 | One-hot port ownership grant to the auxiliary controllers |
| aux_tdi | output | 3 | TDI forwarded to the owning auxiliary controller |
| aux_tdo | input | 3 | Serial outputs of the auxiliary controllers |

## Verification
The instruction-update path and the ownership grant can fall in the same cycle. An Update-IR that arrives while a grant is already active must leave both the current instruction and the grant alone. The bench provokes this by running a full BYPASS instruction scan while auxiliary port 0 owns the port. It then judges the result at the ports: the grant vector, TDO still coming from the owner's `aux_tdo`, and the fact that only a later TMS-driven reset returns an identification read. The same overlap is exercised with TRST in place of the TMS sequence, and the hold register is checked across a SAMPLE scan followed by EXTEST.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  localparam int IR_W  = 5;
  localparam int AUX_N = 3;

  localparam logic [IR_W-1:0] OP_IDCODE  = 5'b00001;
  localparam logic [IR_W-1:0] OP_PRELOAD = 5'b00010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 5'b00011;
  localparam logic [IR_W-1:0] OP_EXTEST  = 5'b00100;
  localparam logic [IR_W-1:0] OP_AUX0    = 5'b11011;
  localparam logic [IR_W-1:0] OP_AUX1    = 5'b10001;
  localparam logic [IR_W-1:0] OP_AUX2    = 5'b10000;
  localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] { DR_BYPASS, DR_ID, DR_BSR } dr_sel_e;

  typedef struct packed {
    dr_sel_e sel;
    logic    load_upd;
    logic    extest;
  } ir_dec_t;

  // Data register choice; reserved and auxiliary codes fall to bypass.
  function automatic ir_dec_t ir_decode(input logic [IR_W-1:0] op);
    ir_dec_t d;
    d = '{sel: DR_BYPASS, load_upd: 1'b0, extest: 1'b0};
    case (op)
      OP_IDCODE:  d.sel = DR_ID;
      OP_PRELOAD: begin d.sel = DR_BSR; d.load_upd = 1'b1; end
      OP_SAMPLE:  d.sel = DR_BSR;
      OP_EXTEST:  begin d.sel = DR_BSR; d.load_upd = 1'b1; d.extest = 1'b1; end
      default:    d.sel = DR_BYPASS;
    endcase
    return d;
  endfunction

  function automatic logic [AUX_N-1:0] aux_decode(input logic [IR_W-1:0] op);
    case (op)
      OP_AUX0: return 3'b001;
      OP_AUX1: return 3'b010;
      OP_AUX2: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (trst) state <= ST_TLR;
    else      state <= nxt;
  end

endmodule

// File: rtl/jtag_ir_unit.sv
module jtag_ir_unit
  import jtag_tap_pkg::*;
(
  input  logic             tck,
  input  logic             trst,
  input  logic             tdi,
  input  tap_state_e       state,
  output logic             ir_lsb,
  output logic [IR_W-1:0]  ir_q,
  output ir_dec_t          dec,
  output logic [AUX_N-1:0] grant
);

  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck) begin
    if (trst) begin
      ir_q  <= OP_IDCODE;
      ir_sh <= '0;
      grant <= '0;
    end else begin
      case (state)
        ST_TLR: begin
          ir_q  <= OP_IDCODE;
          grant <= '0;
        end
        ST_CAP_IR: ir_sh <= IR_CAPTURE;
        ST_SHF_IR: ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        ST_UPD_IR: begin
          // An owned port ignores further instructions until reset.
          if (grant == '0) begin
            ir_q  <= ir_sh;
            grant <= aux_decode(ir_sh);
          end
        end
        default: ;
      endcase
    end
  end

  assign ir_lsb = ir_sh[0];
  assign dec    = ir_decode(ir_q);

endmodule

// File: rtl/jtag_dr_bank.sv
module jtag_dr_bank
  import jtag_tap_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h4BA5_E01D,
  parameter int          BSR_LEN  = 8
) (
  input  logic               tck,
  input  logic               trst,
  input  logic               tdi,
  input  tap_state_e         state,
  input  dr_sel_e            sel,
  input  logic               load_upd,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic               dr_lsb,
  output logic [BSR_LEN-1:0] bsr_hold
);

  localparam int          ID_W    = 32;
  localparam logic [31:0] ID_WORD = {ID_VALUE[ID_W-1:1], 1'b1};

  logic [ID_W-1:0]    id_sr;
  logic [BSR_LEN-1:0] bsr_sr;
  logic               byp;

  always_ff @(posedge tck) begin
    if (trst) begin
      id_sr    <= '0;
      bsr_sr   <= '0;
      byp      <= 1'b0;
      bsr_hold <= '0;
    end else begin
      case (state)
        ST_CAP_DR: begin
          case (sel)
            DR_ID:   id_sr  <= ID_WORD;
            DR_BSR:  bsr_sr <= pin_in;
            default: byp    <= 1'b0;
          endcase
        end
        ST_SHF_DR: begin
          case (sel)
            DR_ID:   id_sr  <= {tdi, id_sr[ID_W-1:1]};
            DR_BSR:  bsr_sr <= {tdi, bsr_sr[BSR_LEN-1:1]};
            default: byp    <= tdi;
          endcase
        end
        ST_UPD_DR: if (load_upd) bsr_hold <= bsr_sr;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      DR_ID:   dr_lsb = id_sr[0];
      DR_BSR:  dr_lsb = bsr_sr[0];
      default: dr_lsb = byp;
    endcase
  end

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h4BA5_E01D,
  parameter int          BSR_LEN  = 8
) (
  input  logic               tck,
  input  logic               trst,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] pin_in,
  input  logic [BSR_LEN-1:0] core_out,
  output logic [BSR_LEN-1:0] pad_out,
  output logic               func_reset,
  output logic [AUX_N-1:0]   aux_grant,
  output logic [AUX_N-1:0]   aux_tdi,
  input  logic [AUX_N-1:0]   aux_tdo
);

  tap_state_e         state;
  ir_dec_t            dec;
  logic [IR_W-1:0]    cur_ir;
  logic               ir_lsb;
  logic               dr_lsb;
  logic [BSR_LEN-1:0] bsr_hold;
  logic               tdo_r;
  logic               oe_r;
  logic               owned;

  jtag_tap_fsm u_fsm (
    .tck(tck), .trst(trst), .tms(tms), .state(state)
  );

  jtag_ir_unit u_ir (
    .tck(tck), .trst(trst), .tdi(tdi), .state(state),
    .ir_lsb(ir_lsb), .ir_q(cur_ir), .dec(dec), .grant(aux_grant)
  );

  jtag_dr_bank #(.ID_VALUE(ID_VALUE), .BSR_LEN(BSR_LEN)) u_dr (
    .tck(tck), .trst(trst), .tdi(tdi), .state(state),
    .sel(dec.sel), .load_upd(dec.load_upd), .pin_in(pin_in),
    .dr_lsb(dr_lsb), .bsr_hold(bsr_hold)
  );

  // Serial output launched on the falling edge.
  always_ff @(negedge tck) begin
    if (trst) begin
      tdo_r <= 1'b0;
      oe_r  <= 1'b0;
    end else begin
      oe_r <= (state == ST_SHF_IR) || (state == ST_SHF_DR);
      if (state == ST_SHF_IR)      tdo_r <= ir_lsb;
      else if (state == ST_SHF_DR) tdo_r <= dr_lsb;
    end
  end

  genvar g;
  generate
    for (g = 0; g < AUX_N; g++) begin : g_aux
      assign aux_tdi[g] = aux_grant[g] & tdi;
    end
  endgenerate

  assign owned      = |aux_grant;
  assign tdo        = owned ? |(aux_tdo & aux_grant) : tdo_r;
  assign tdo_oe     = owned | oe_r;
  assign func_reset = dec.extest;
  assign pad_out    = dec.extest ? bsr_hold : core_out;

endmodule

// File: rtl/jtag_tap_ctrl_chk.sv
module jtag_tap_ctrl_chk
  import jtag_tap_pkg::*;
(
  input logic             tck,
  input logic             trst,
  input logic             tms,
  input logic             tdo_oe,
  input logic [AUX_N-1:0] aux_grant,
  input tap_state_e       state,
  input logic [IR_W-1:0]  cur_ir
);

  AST_RESET_CLEARS: assert property (@(posedge tck)
    trst |=> (aux_grant == '0 && cur_ir == OP_IDCODE)); // R1

  AST_FIVE_HIGH_RESET: assert property (@(posedge tck) disable iff (trst)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
    |=> state == ST_TLR); // R1

  AST_IR_ONLY_ON_UPDATE: assert property (@(posedge tck) disable iff (trst)
    (state != ST_UPD_IR && state != ST_TLR) |=> $stable(cur_ir)); // R3

  AST_GRANT_ONEHOT: assert property (@(posedge tck) disable iff (trst)
    $onehot0(aux_grant)); // R9

  AST_GRANT_HOLDS: assert property (@(posedge tck) disable iff (trst)
    ((aux_grant != '0) && state != ST_TLR) |=> $stable(aux_grant)); // R10

  AST_OE_SHIFT_ONLY: assert property (@(posedge tck) disable iff (trst)
    (tdo_oe && aux_grant == '0) |-> (state == ST_SHF_IR || state == ST_SHF_DR)); // R12

endmodule

bind jtag_tap_ctrl jtag_tap_ctrl_chk u_chk (
  .tck(tck), .trst(trst), .tms(tms), .tdo_oe(tdo_oe),
  .aux_grant(aux_grant), .state(state), .cur_ir(cur_ir)
);

// File: tb/jtag_tap_ctrl_tb.sv
module jtag_tap_ctrl_tb;

  localparam int          TCK_PERIOD = 10;
  localparam int          BSR_LEN    = 8;
  localparam logic [31:0] ID_VAL     = 32'h4BA5_E01D;

  logic               tck = 1'b0;
  logic               trst, tms, tdi;
  logic               tdo, tdo_oe, func_reset;
  logic [BSR_LEN-1:0] pin_in, core_out, pad_out;
  logic [2:0]         aux_grant, aux_tdi, aux_tdo;

  int n_chk = 0;
  int n_err = 0;

  jtag_tap_ctrl #(.ID_VALUE(ID_VAL), .BSR_LEN(BSR_LEN)) u_dut (
    .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_in(pin_in), .core_out(core_out), .pad_out(pad_out),
    .func_reset(func_reset), .aux_grant(aux_grant), .aux_tdi(aux_tdi),
    .aux_tdo(aux_tdo)
  );

  always #(TCK_PERIOD / 2) tck = ~tck;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Sample TDO for the current state, drive, then advance one TCK.
  task automatic tick(input logic m, input logic d, output logic o);
    o   = tdo;
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic ir_scan(input logic [4:0] op, output logic [4:0] cap);
    logic o;
    tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < 5; i++) begin
      tick(i == 4, op[i], o);
      cap[i] = o;
    end
    tick(1, 0, o); tick(0, 0, o);
  endtask

  task automatic dr_scan(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic o;
    dout = '0;
    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], o);
      dout[i] = o;
    end
    tick(1, 0, o); tick(0, 0, o);
  endtask

  task automatic tms_reset();
    logic o;
    for (int i = 0; i < 5; i++) tick(1, 0, o);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    logic o;
    tick(0, 0, o);
    chk("R1 grant after trst", 64'(aux_grant), 64'd0);
    chk("R1 func_reset after trst", 64'(func_reset), 64'd0);
    chk("R12 oe idle", 64'(tdo_oe), 64'd0);
    dr_scan(32, 64'd0, d);
    chk("R1 R4 idcode after reset", d, 64'(ID_VAL));
    chk("R4 id bit0", 64'(d[0]), 64'd1);
  endtask

  task automatic t_ir_capture();
    logic [4:0] c;
    ir_scan(5'b00001, c);
    chk("R2 capture-IR pattern", 64'(c), 64'h01);
  endtask

  task automatic t_bypass(input logic [4:0] op, input string tag);
    logic [4:0] c;
    logic [63:0] d;
    ir_scan(op, c);
    dr_scan(6, 64'b101101, d);
    chk(tag, d, 64'b011010);
  endtask

  task automatic t_partial();
    logic [4:0] c;
    logic [63:0] d;
    ir_scan(5'b00001, c);
    dr_scan(7, 64'h7F, d);
    chk("R11 partial id bits", d, 64'(ID_VAL[6:0]));
    dr_scan(32, 64'd0, d);
    chk("R11 full reload after partial", d, 64'(ID_VAL));
    chk("R3 instruction kept across scans", 64'(d[0]), 64'd1);
  endtask

  task automatic t_boundary();
    logic [4:0] c;
    logic [63:0] d;
    pin_in = 8'hA5; core_out = 8'h0F;
    ir_scan(5'b00010, c);
    dr_scan(BSR_LEN, 64'h3C, d);
    chk("R6 preload capture", d, 64'hA5);
    chk("R6 pads follow core", 64'(pad_out), 64'h0F);
    chk("R6 no func reset", 64'(func_reset), 64'd0);
    pin_in = 8'h5A;
    ir_scan(5'b00011, c);
    dr_scan(BSR_LEN, 64'hFF, d);
    chk("R7 sample capture", d, 64'h5A);
    chk("R7 pads follow core", 64'(pad_out), 64'h0F);
    ir_scan(5'b00100, c);
    chk("R7 R8 hold kept from preload", 64'(pad_out), 64'h3C);
    chk("R8 func reset", 64'(func_reset), 64'd1);
    dr_scan(BSR_LEN, 64'h81, d);
    chk("R8 extest capture", d, 64'h5A);
    chk("R8 extest update", 64'(pad_out), 64'h81);
  endtask

  task automatic t_oe_edge();
    logic [4:0] c;
    logic o;
    ir_scan(5'b11111, c);
    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    chk("R12 oe in shift-DR", 64'(tdo_oe), 64'd1);
    chk("R12 bypass captured", 64'(tdo), 64'd0);
    tdi = 1'b1;
    @(posedge tck); #1;
    chk("R12 tdo held past rising edge", 64'(tdo), 64'd0);
    @(negedge tck); #1;
    chk("R12 tdo moves on falling edge", 64'(tdo), 64'd1);
    tick(1, 0, o); tick(1, 0, o); tick(0, 0, o);
    chk("R12 oe off after scan", 64'(tdo_oe), 64'd0);
  endtask

  // Grant arrives, then an Update-IR overlaps with the active grant.
  task automatic t_aux();
    logic [4:0] c;
    logic [63:0] d;
    logic o;
    ir_scan(5'b11011, c);
    chk("R9 grant aux0", 64'(aux_grant), 64'b001);
    aux_tdo = 3'b110; #1;
    chk("R9 tdo from owner low", 64'(tdo), 64'd0);
    aux_tdo = 3'b001; #1;
    chk("R9 tdo from owner high", 64'(tdo), 64'd1);
    chk("R9 oe while owned", 64'(tdo_oe), 64'd1);
    tdi = 1'b1; #1;
    chk("R9 tdi routed to owner", 64'(aux_tdi), 64'b001);
    ir_scan(5'b11111, c);
    chk("R10 grant survives IR scan", 64'(aux_grant), 64'b001);
    dr_scan(4, 64'h0, d);
    chk("R10 tdo still owner", d, 64'hF);
    tms_reset();
    tick(0, 0, o);
    chk("R1 R10 tms reset clears grant", 64'(aux_grant), 64'd0);
    dr_scan(32, 64'd0, d);
    chk("R1 idcode after tms reset", d, 64'(ID_VAL));
    ir_scan(5'b10001, c);
    chk("R9 grant aux1", 64'(aux_grant), 64'b010);
    trst = 1'b1; tick(1, 0, o); trst = 1'b0; tick(0, 0, o);
    chk("R1 trst clears grant", 64'(aux_grant), 64'd0);
    ir_scan(5'b10000, c);
    chk("R9 grant aux2", 64'(aux_grant), 64'b100);
    tdi = 1'b0; #1;
    chk("R9 tdi gated low", 64'(aux_tdi), 64'b000);
    tms_reset();
    tick(0, 0, o);
    chk("R10 cleared again", 64'(aux_grant), 64'd0);
  endtask

  initial begin
    trst = 1'b1; tms = 1'b1; tdi = 1'b0;
    pin_in = '0; core_out = '0; aux_tdo = '0;
    repeat (3) @(negedge tck);
    #1;
    trst = 1'b0;
    t_reset();
    t_ir_capture();
    t_bypass(5'b11111, "R5 bypass 11111");
    t_bypass(5'b00101, "R5 reserved 00101");
    t_bypass(5'b01010, "R5 reserved 01010");
    t_bypass(5'b01111, "R5 unlisted 01111");
    t_partial();
    t_boundary();
    t_oe_edge();
    t_aux();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge tck);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule